// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block holds the program counter of a single-cycle processor and chooses the address it moves to on every rising clock edge. The instruction memory is addressed directly by the current PC. The decoded instruction supplies a 16-bit offset field and a 26-bit target field. The control decoder supplies a branch select and a jump select, and the datapath comparator supplies an equality flag.

All three candidate addresses are formed combinationally from the current PC in the same cycle:
- the sequential address is PC + 4;
- the PC-relative branch address is PC + 4 + (sign-extended offset shifted left by two);
- the pseudo-direct jump address keeps the top four PC bits, inserts the target field and appends two zero bits.

The selected candidate loads on the next edge. A synchronous reset returns the PC to its start address.

Top module: `pc_fetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: When `jump_sel_i` is 0 and `branch_sel_i` AND `equal_i` is 0, the PC advances to PC + 4.
- R3: When `jump_sel_i` is 0 and both `branch_sel_i` and `equal_i` are 1, the PC becomes PC + 4 + ({sign-extended `imm_i`, 2'b00}). `imm_i` bit 15 is the sign bit, so negative offsets branch backwards.
- R4: Only one of `branch_sel_i` and `equal_i` being high never redirects the PC. The result is PC + 4.
- R5: When `jump_sel_i` is 1, the PC becomes {PC[31:28], `target_i`[25:0], 2'b00}.
- R6: With `jump_sel_i` high, `branch_sel_i` and `equal_i` have no effect on the next PC.
- R7: `pc_o[1:0]` is always 00 after reset.
- R8: Address arithmetic wraps modulo 2^32. A backward branch from 0 lands at the top of the address space, and PC + 4 from 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imm_i | input | 16 | Branch offset field, in words |
| target_i | input | 26 | Jump target field, in words |
| branch_sel_i | input | 1 | Current instruction is a conditional branch |
| jump_sel_i | input | 1 | Current instruction is a jump |
| equal_i | input | 1 | The two compared registers are equal |
| pc_o | output | 32 | Current PC, drives the instruction memory address |

## Verification
The bound checker tests every cycle that:
- the PC follows the selected rule relative to its previous value, for the sequential, branch-taken and jump cases;
- reset forces zero;
- the two low PC bits stay clear.

Some cases are shown only by the bench scenarios, which replay chosen sequences against an independent model:
- a backward branch that wraps below zero, followed by an increment that wraps back to zero;
- a jump that keeps a nonzero upper nibble;
- a jump presented together with a true branch condition;
- a reset applied in the middle of a run.

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic              branch_sel_i,
  input  logic              jump_sel_i,
  input  logic              equal_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int ALIGN = 2;
  localparam int EXT_W = ADDR_W - IMM_W - ALIGN;
  localparam int HI_W  = ADDR_W - TGT_W - ALIGN;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN);

  logic [ADDR_W-1:0] pc_q, seq_pc, br_off, br_pc, jmp_pc, nxt_pc;
  logic take_br;

  assign seq_pc  = pc_q + STEP;
  assign br_off  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN{1'b0}}};
  assign br_pc   = seq_pc + br_off;
  assign jmp_pc  = {pc_q[ADDR_W-1 -: HI_W], target_i, {ALIGN{1'b0}}};
  assign take_br = branch_sel_i & equal_i;

  always_comb begin
    if (jump_sel_i)   nxt_pc = jmp_pc;
    else if (take_br) nxt_pc = br_pc;
    else              nxt_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= nxt_pc;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_fetch_unit_chk.sv
module pc_fetch_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic [IMM_W-1:0]  imm_i,
  input logic [TGT_W-1:0]  target_i,
  input logic              branch_sel_i,
  input logic              jump_sel_i,
  input logic              equal_i,
  input logic [ADDR_W-1:0] pc_o
);
  localparam int HI_W = ADDR_W - TGT_W - 2;

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc_o == '0);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jump_sel_i && !(branch_sel_i && equal_i)) |=> pc_o == $past(pc_o) + ADDR_W'(4));

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!jump_sel_i && branch_sel_i && equal_i) |=>
      pc_o == $past(pc_o) + ADDR_W'(4) +
              {{(ADDR_W-IMM_W-2){$past(imm_i[IMM_W-1])}}, $past(imm_i), 2'b00});

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump_sel_i |=> pc_o == {$past(pc_o[ADDR_W-1 -: HI_W]), $past(target_i), 2'b00});

  a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

bind pc_fetch_unit pc_fetch_unit_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
  .branch_sel_i(branch_sel_i), .jump_sel_i(jump_sel_i), .equal_i(equal_i), .pc_o(pc_o)
);

// File: tb/pc_fetch_unit_tb.sv
module pc_fetch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic        branch_sel_i = 1'b0;
  logic        jump_sel_i = 1'b0;
  logic        equal_i = 1'b0;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mpc = '0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pc_fetch_unit u_dut (
    .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
    .branch_sel_i(branch_sel_i), .jump_sel_i(jump_sel_i), .equal_i(equal_i), .pc_o(pc_o)
  );

  task automatic step(input bit r, input bit br, input bit eq, input bit jp,
                      input logic [15:0] imm, input logic [25:0] tgt, input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    rst = r; branch_sel_i = br; equal_i = eq; jump_sel_i = jp;
    imm_i = imm; target_i = tgt;
    if (r)            nxt = 32'h0;
    else if (jp)      nxt = {mpc[31:28], tgt, 2'b00};
    else if (br & eq) nxt = mpc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else              nxt = mpc + 32'd4;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    mpc = nxt;
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc_o !== e) begin
        errors++;
        $display("FAIL %s: pc_o actual %h expected %h", t, pc_o, e);
      end
      checks++;
      if (pc_o[1:0] !== 2'b00) begin
        errors++;
        $display("FAIL R7: pc_o low bits actual %b expected 00", pc_o[1:0]);
      end
    end
  end

  initial begin
    step(1, 1, 1, 1, 16'h0010, 26'h3ABCDEF, "R1");
    step(1, 0, 0, 0, 16'h0000, 26'h0, "R1");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2");
    step(0, 0, 0, 0, 16'h1234, 26'h0, "R2");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2");
    step(0, 1, 1, 0, 16'h0010, 26'h0, "R3");
    step(0, 1, 0, 0, 16'h0040, 26'h0, "R4");
    step(0, 0, 1, 0, 16'h0040, 26'h0, "R4");
    step(0, 1, 1, 0, 16'hFFF8, 26'h0, "R3");
    step(0, 1, 1, 0, 16'h7FFF, 26'h0, "R3");
    step(0, 0, 0, 1, 16'h0000, 26'h0000100, "R5");
    step(0, 1, 1, 1, 16'h0100, 26'h0000200, "R6");
    step(0, 1, 0, 1, 16'hFFFF, 26'h1555555, "R6");
    step(1, 0, 0, 0, 16'h0000, 26'h0, "R1");
    step(0, 1, 1, 0, 16'hFFFE, 26'h0, "R8");
    step(0, 0, 0, 1, 16'h0000, 26'h3FFFFFF, "R5");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R8");
    step(0, 0, 0, 1, 16'h0000, 26'h0000040, "R5");
    step(0, 1, 1, 0, 16'hFFFF, 26'h0, "R3");
    step(1, 0, 1, 0, 16'h0000, 26'h0, "R1");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule